// File: doc/BRIEF.md
# Peripheral Clock Frequency Calculator

This block reports the frequency, in hertz as a 32-bit number, of a chosen on-chip clock. It reads a clock-control word, a post-divider word and the PLL output frequency, which another part of the chip computes and supplies. From these it picks a reference source and a main clock, then divides twice in sequence. The first division gives the fast bus clock and the second gives the peripheral clock.

A request is a one-cycle `start_i` pulse with a clock selection. Selections that need no arithmetic finish on the next cycle. The peripheral selections run through a single radix-2 sequential divider twice. The block then raises `done_o` for one cycle. The result and the unsupported flag stay unchanged until the next accepted request finishes.

Top module: `pclk_freq_calc`

## Requirements
- R1: After synchronous reset, `freq_hz_o`, `done_o`, `unsup_o` and `busy_o` are all 0.
- R2: When control bits [2:1] (reference select) are any value other than 2, the reference frequency is 26,000,000 Hz.
- R3: When reference select is 2, control bit 3 (low-frequency enable) is 1 and control bit 4 (x1024 factor) is 0, the reference is 32,768 Hz.
- R4: When reference select is 2 and control bits 3 and 4 are both 1, the reference is 32,768 x 1024 = 33,554,432 Hz.
- R5: When reference select is 2 and control bit 3 is 0, the reference is 0 Hz, whatever bit 4 holds.
- R6: The main clock is the PLL frequency input when control bit 0 (PLL enable) is 1 and control bit 7 (PLL bypass) is 0. Otherwise the main clock is the reference.
- R7: The peripheral frequency is floor(floor(main / (B + 1)) / (P + 1)). B is post-divider bits [5:3] and P is post-divider bits [7:6]. All other post-divider bits have no effect.
- R8: Clock select 1 and 2 both report the peripheral frequency. Select 3 reports 32,768. Select 0 reports 0. `unsup_o` is 0 for all four.
- R9: Clock select 4 to 7 reports 0 with `unsup_o` set to 1.
- R10: `done_o` is high for exactly one cycle per accepted request. `freq_hz_o` and `unsup_o` do not change except in a cycle where `done_o` is high.
- R11: `busy_o` is high from the cycle after an accepted peripheral request until `done_o`. A `start_i` pulse while `busy_o` is high is ignored: it produces no extra `done_o` and does not alter the pending result.
- R12: With data width W, `done_o` is high 1 cycle after the `start_i` cycle for select 0, 3 and 4 to 7, and 2*W+3 cycles after it for select 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle request pulse |
| clk_sel_i | input | 3 | Which clock to report |
| ctrl_i | input | 32 | Clock-control word |
| pdiv_i | input | 32 | Post-divider word |
| pll_hz_i | input | 32 | PLL output frequency in Hz |
| busy_o | output | 1 | A divided request is in progress |
| done_o | output | 1 | One-cycle result-valid pulse |
| freq_hz_o | output | 32 | Reported frequency in Hz |
| unsup_o | output | 1 | Last request used an unsupported selection |

## Verification
The bench covers each reference path separately:
- crystal,
- plain low-frequency,
- x1024 low-frequency,
- disabled low-frequency.

A mix-up between any two of these shows up as a wrong power of 1024 or as a non-zero value where zero is expected. It runs divisor fields at 0 and at their maximum, with non-integer quotients. A design that rounds instead of truncating, or that applies the two divisors in the wrong order or to the wrong bits, gives results that differ by one or more. The post-divider word is loaded with ones outside its two fields, which catches field decodes that are off by one bit. A second start pulse while busy, a hold period with changing inputs, and exact latency counts expose a design that restarts, drops the result or emits a stray done.

// File: rtl/pclk_freq_pkg.sv
// Package: shared constants, bit positions and types for the frequency calculator.
// Assumes: 32-bit control and post-divider words; bit positions below are fixed.
package pclk_freq_pkg;

    localparam int FREQ_W = 32;
    localparam int REG_W  = 32;

    localparam logic [FREQ_W-1:0] CRYSTAL_HZ   = 32'd26_000_000;
    localparam logic [FREQ_W-1:0] LOWF_HZ      = 32'd32_768;
    localparam int                LOWF_X_SHIFT = 10;   // x1024

    // control word bit positions
    localparam int CTL_PLL_EN  = 0;
    localparam int CTL_REF_LSB = 1;
    localparam int CTL_REF_W   = 2;
    localparam int CTL_LF_EN   = 3;
    localparam int CTL_LF_X    = 4;
    localparam int CTL_BYPASS  = 7;
    localparam logic [CTL_REF_W-1:0] REF_SEL_LOWF = 2'd2;

    // post-divider field positions: index 0 = bus stage, index 1 = peripheral stage
    localparam int N_STAGE = 2;
    localparam int DIV_FLD_W_MAX = 3;

    // clock select codes
    localparam logic [2:0] SEL_NONE    = 3'd0;
    localparam logic [2:0] SEL_PERIPH  = 3'd1;
    localparam logic [2:0] SEL_PER_HI  = 3'd2;
    localparam logic [2:0] SEL_LOWF    = 3'd3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STAGE1 = 2'd1,
        ST_STAGE2 = 2'd2
    } calc_state_t;

    function automatic int fld_lsb(input int idx);
        return (idx == 0) ? 3 : 6;
    endfunction

    function automatic int fld_w(input int idx);
        return (idx == 0) ? 3 : 2;
    endfunction

endpackage

// File: rtl/pclk_src_select.sv
// Module: picks the reference source and the main clock from the control word.
// Assumes: purely combinational; the PLL frequency is computed elsewhere.
module pclk_src_select
    import pclk_freq_pkg::*;
#(
    parameter int W = FREQ_W
) (
    input  logic [REG_W-1:0] ctrl_i,
    input  logic [W-1:0]     pll_hz_i,
    output logic [W-1:0]     ref_hz_o,
    output logic [W-1:0]     main_hz_o
);

    logic [CTL_REF_W-1:0] ref_sel;
    logic                 lf_en;
    logic                 lf_x;
    logic                 use_pll;

    assign ref_sel = ctrl_i[CTL_REF_LSB +: CTL_REF_W];
    assign lf_en   = ctrl_i[CTL_LF_EN];
    assign lf_x    = ctrl_i[CTL_LF_X];
    assign use_pll = ctrl_i[CTL_PLL_EN] && !ctrl_i[CTL_BYPASS];

    // Reference: crystal, low-frequency input (optionally x1024) or nothing.
    always_comb begin
        if (ref_sel != REF_SEL_LOWF) begin
            ref_hz_o = W'(CRYSTAL_HZ);
        end else if (!lf_en) begin
            ref_hz_o = '0;
        end else if (lf_x) begin
            ref_hz_o = W'(LOWF_HZ) << LOWF_X_SHIFT;
        end else begin
            ref_hz_o = W'(LOWF_HZ);
        end
    end

    // Main clock: PLL output only when enabled and not bypassed.
    always_comb begin
        main_hz_o = use_pll ? pll_hz_i : ref_hz_o;
    end

endmodule

// File: rtl/pclk_div_fields.sv
// Module: extracts the two divide-by-(field+1) divisors from the post-divider word.
// Assumes: field positions come from the package; divisors are never zero.
module pclk_div_fields
    import pclk_freq_pkg::*;
#(
    parameter int W = FREQ_W
) (
    input  logic [REG_W-1:0] pdiv_i,
    output logic [W-1:0]     bus_dvs_o,
    output logic [W-1:0]     per_dvs_o
);

    logic [W-1:0] dvs [N_STAGE];

    // One extractor per divider stage.
    for (genvar g = 0; g < N_STAGE; g++) begin : g_fld
        localparam int LSB = fld_lsb(g);
        localparam int FW  = fld_w(g);
        logic [FW-1:0] raw;
        assign raw    = pdiv_i[LSB +: FW];
        assign dvs[g] = W'(raw) + W'(1);
    end

    assign bus_dvs_o = dvs[0];
    assign per_dvs_o = dvs[1];

endmodule

// File: rtl/pclk_seq_div.sv
// Module: restoring radix-2 unsigned divider, one quotient bit per cycle.
// Assumes: divisor is non-zero; go_i is only honoured while idle; the
// quotient stays valid after fin_o until the next go_i.
module pclk_seq_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quot_o,
    output logic         fin_o,
    output logic         run_o
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  rem_q;
    logic [W-1:0]  quo_q;
    logic [W-1:0]  dvs_q;
    logic [CW-1:0] cnt_q;
    logic          run_q;
    logic          fin_q;

    logic [W:0]    shifted;
    logic [W+1:0]  diff;
    logic [W-1:0]  rem_nx;
    logic [W-1:0]  quo_nx;

    // One restoring step: shift in the next dividend bit, try to subtract.
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        diff    = {1'b0, shifted} - {2'b00, dvs_q};
        if (!diff[W+1]) begin
            rem_nx = diff[W-1:0];
            quo_nx = {quo_q[W-2:0], 1'b1};
        end else begin
            rem_nx = shifted[W-1:0];
            quo_nx = {quo_q[W-2:0], 1'b0};
        end
    end

    // Load on go, then iterate W steps and pulse fin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            quo_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            run_q <= 1'b0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (go_i && !run_q) begin
                quo_q <= dividend_i;
                rem_q <= '0;
                dvs_q <= divisor_i;
                cnt_q <= CW'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                rem_q <= rem_nx;
                quo_q <= quo_nx;
                cnt_q <= cnt_q - CW'(1);
                if (cnt_q == CW'(1)) begin
                    run_q <= 1'b0;
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign quot_o = quo_q;
    assign fin_o  = fin_q;
    assign run_o  = run_q;

endmodule

// File: rtl/pclk_freq_calc.sv
// Module: top of the frequency calculator. Sequences one shared divider
// through the bus stage and then the peripheral stage, or answers fixed
// selections at once.
// Assumes: start pulses arriving while busy are dropped; results hold until
// the next accepted request finishes.
module pclk_freq_calc
    import pclk_freq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        clk_sel_i,
    input  logic [REG_W-1:0]  ctrl_i,
    input  logic [REG_W-1:0]  pdiv_i,
    input  logic [FREQ_W-1:0] pll_hz_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [FREQ_W-1:0] freq_hz_o,
    output logic              unsup_o
);

    localparam int W = FREQ_W;

    calc_state_t  state_q;
    logic [W-1:0] per_dvs_q;
    logic [W-1:0] freq_q;
    logic         done_q;
    logic         unsup_q;

    logic [W-1:0] ref_hz;
    logic [W-1:0] main_hz;
    logic [W-1:0] bus_dvs;
    logic [W-1:0] per_dvs;
    logic         div_go;
    logic [W-1:0] div_dividend;
    logic [W-1:0] div_divisor;
    logic [W-1:0] div_quot;
    logic         div_fin;
    logic         div_run;
    logic         sel_divided;
    logic         sel_known;
    logic         accept;

    pclk_src_select #(.W(W)) u_src (
        .ctrl_i    (ctrl_i),
        .pll_hz_i  (pll_hz_i),
        .ref_hz_o  (ref_hz),
        .main_hz_o (main_hz)
    );

    pclk_div_fields #(.W(W)) u_fld (
        .pdiv_i    (pdiv_i),
        .bus_dvs_o (bus_dvs),
        .per_dvs_o (per_dvs)
    );

    pclk_seq_div #(.W(W)) u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .go_i       (div_go),
        .dividend_i (div_dividend),
        .divisor_i  (div_divisor),
        .quot_o     (div_quot),
        .fin_o      (div_fin),
        .run_o      (div_run)
    );

    // Decode the selection and decide whether a request is taken.
    always_comb begin
        sel_divided = (clk_sel_i == SEL_PERIPH) || (clk_sel_i == SEL_PER_HI);
        sel_known   = sel_divided || (clk_sel_i == SEL_NONE) || (clk_sel_i == SEL_LOWF);
        accept      = (state_q == ST_IDLE) && start_i;
    end

    // Feed the shared divider: main/bus on accept, then bus-result/peripheral.
    always_comb begin
        div_go       = 1'b0;
        div_dividend = main_hz;
        div_divisor  = bus_dvs;
        if (state_q == ST_IDLE) begin
            div_go = accept && sel_divided;
        end else if (state_q == ST_STAGE1) begin
            div_go       = div_fin;
            div_dividend = div_quot;
            div_divisor  = per_dvs_q;
        end
    end

    // Request sequencing, result register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            per_dvs_q <= '0;
            freq_q    <= '0;
            done_q    <= 1'b0;
            unsup_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        if (sel_divided) begin
                            per_dvs_q <= per_dvs;
                            state_q   <= ST_STAGE1;
                        end else begin
                            freq_q  <= (clk_sel_i == SEL_LOWF) ? W'(LOWF_HZ) : '0;
                            unsup_q <= !sel_known;
                            done_q  <= 1'b1;
                        end
                    end
                end
                ST_STAGE1: begin
                    if (div_fin) state_q <= ST_STAGE2;
                end
                ST_STAGE2: begin
                    if (div_fin) begin
                        freq_q  <= div_quot;
                        unsup_q <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o    = (state_q != ST_IDLE);
    assign done_o    = done_q;
    assign freq_hz_o = freq_q;
    assign unsup_o   = unsup_q;

endmodule

// File: rtl/pclk_freq_calc_chk.sv
// Module: property checker for the frequency calculator, bound to the top.
// Assumes: observes ports only; latency window tracked with a counter.
module pclk_freq_calc_chk
    import pclk_freq_pkg::*;
#(
    parameter int W = FREQ_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [2:0]   clk_sel_i,
    input logic         busy_o,
    input logic         done_o,
    input logic [W-1:0] freq_hz_o,
    input logic         unsup_o
);

    localparam int BUSY_LIM = 2 * W + 2;

    logic [15:0] busy_cnt;

    // Count consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_cnt <= '0;
        else if (busy_o) busy_cnt <= busy_cnt + 16'd1;
        else busy_cnt <= '0;
    end

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_hold_freq_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(freq_hz_o) && $stable(unsup_o)));

    p_unsup_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && unsup_o) |-> (freq_hz_o == '0));

    p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_lowf_direct_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && clk_sel_i == SEL_LOWF) |=>
            (done_o && freq_hz_o == W'(LOWF_HZ) && !unsup_o));

    p_unsup_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && clk_sel_i[2]) |=> (done_o && unsup_o));

    p_busy_bound_r12: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (busy_cnt < 16'(BUSY_LIM)));

endmodule

bind pclk_freq_calc pclk_freq_calc_chk #(.W(pclk_freq_pkg::FREQ_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .clk_sel_i (clk_sel_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .freq_hz_o (freq_hz_o),
    .unsup_o   (unsup_o)
);

// File: tb/pclk_freq_calc_tb.sv
// Scoreboard bench: driver task queues expected results, monitor compares on done.
module pclk_freq_calc_tb;

    localparam int W = 32;

    typedef struct {
        logic [31:0] f;
        logic        u;
        longint      due;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [2:0]  clk_sel_i = '0;
    logic [31:0] ctrl_i = '0;
    logic [31:0] pdiv_i = '0;
    logic [31:0] pll_hz_i = '0;
    logic        busy_o;
    logic        done_o;
    logic [31:0] freq_hz_o;
    logic        unsup_o;

    exp_t   exp_q[$];
    exp_t   mon_e;
    longint cyc = 0;
    int     n_chk = 0;
    int     n_bad = 0;
    bit     ended = 1'b0;

    pclk_freq_calc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .clk_sel_i (clk_sel_i),
        .ctrl_i    (ctrl_i),
        .pdiv_i    (pdiv_i),
        .pll_hz_i  (pll_hz_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .freq_hz_o (freq_hz_o),
        .unsup_o   (unsup_o)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // control word built from the requirement bit positions
    function automatic logic [31:0] mk_ctrl(input bit pll_en, input logic [1:0] rsel,
                                            input bit lf_en, input bit lf_x, input bit byp);
        logic [31:0] c = '0;
        c[0] = pll_en; c[2:1] = rsel; c[3] = lf_en; c[4] = lf_x; c[7] = byp;
        return c;
    endfunction

    function automatic logic [31:0] mk_pdiv(input logic [2:0] b, input logic [1:0] p,
                                            input logic [31:0] junk);
        return (junk & ~32'h0000_00F8) | {24'd0, p, b, 3'd0};
    endfunction

    // reference model from the requirements: {unsupported, frequency}
    function automatic logic [32:0] model(input logic [2:0] sel, input logic [31:0] c,
                                          input logic [31:0] d, input logic [31:0] pll);
        longint unsigned rf, mn, h, p;
        if (sel == 3'd0) return {1'b0, 32'd0};
        if (sel == 3'd3) return {1'b0, 32'd32768};
        if (sel >= 3'd4) return {1'b1, 32'd0};
        if (c[2:1] != 2'd2) rf = 26000000;
        else if (!c[3]) rf = 0;
        else if (c[4]) rf = 32768 * 1024;
        else rf = 32768;
        mn = (c[0] && !c[7]) ? longint'(pll) : rf;
        h = mn / (longint'(d[5:3]) + 1);
        p = h / (longint'(d[7:6]) + 1);
        return {1'b0, p[31:0]};
    endfunction

    task automatic check(input string tag, input bit ok, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // driver: apply one request, queue its expected outcome, wait for it
    task automatic run_req(input string tag, input logic [2:0] sel, input logic [31:0] c,
                           input logic [31:0] d, input logic [31:0] pll);
        exp_t e;
        logic [32:0] m;
        @(negedge clk);
        clk_sel_i = sel; ctrl_i = c; pdiv_i = d; pll_hz_i = pll; start_i = 1'b1;
        m = model(sel, c, d, pll);
        e.f = m[31:0]; e.u = m[32]; e.tag = tag;
        e.due = cyc + ((sel == 3'd1 || sel == 3'd2) ? longint'(2 * W + 3) : 1);
        exp_q.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // monitor: compare value, flag and latency on every done
    always @(posedge clk) begin
        #1;
        if (rst_n && done_o) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected done", 1'b0, freq_hz_o, 32'd0);
            end else begin
                mon_e = exp_q.pop_front();
                n_chk++;
                if (freq_hz_o !== mon_e.f || unsup_o !== mon_e.u || cyc != mon_e.due) begin
                    n_bad++;
                    $display("FAIL %s actual f=%0d u=%0b cyc=%0d expected f=%0d u=%0b cyc=%0d",
                             mon_e.tag, freq_hz_o, unsup_o, cyc, mon_e.f, mon_e.u, mon_e.due);
                end
            end
        end
    end

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] held_f;
        logic        held_u;
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1;
        check("R1 reset freq", freq_hz_o == 0, freq_hz_o, 0);
        check("R1 reset flags", {done_o, unsup_o, busy_o} == 3'b000,
              {29'd0, done_o, unsup_o, busy_o}, 0);

        run_req("R2 R7 crystal bypass /4 /2", 3'd1, mk_ctrl(1, 2'd0, 0, 0, 1),
                mk_pdiv(3'd3, 2'd1, 0), 32'd500_000_000);
        run_req("R6 pll used /8 /4 alias R8", 3'd2, mk_ctrl(1, 2'd0, 0, 0, 0),
                mk_pdiv(3'd7, 2'd3, 0), 32'd399_000_000);
        run_req("R6 pll disabled /1 /1", 3'd1, mk_ctrl(0, 2'd1, 0, 0, 0),
                mk_pdiv(3'd0, 2'd0, 0), 32'd399_000_000);
        run_req("R3 lowf /3 /3 truncation", 3'd1, mk_ctrl(0, 2'd2, 1, 0, 0),
                mk_pdiv(3'd2, 2'd2, 0), 32'd1);
        run_req("R4 lowf x1024 /6 /2", 3'd1, mk_ctrl(1, 2'd2, 1, 1, 1),
                mk_pdiv(3'd5, 2'd1, 0), 32'd7);
        run_req("R5 lowf disabled", 3'd2, mk_ctrl(0, 2'd2, 0, 1, 0),
                mk_pdiv(3'd0, 2'd0, 0), 32'd100);
        run_req("R2 ref select 3 crystal", 3'd1, mk_ctrl(0, 2'd3, 1, 1, 0),
                mk_pdiv(3'd1, 2'd0, 0), 32'd0);
        run_req("R7 other pdiv bits ignored", 3'd1, mk_ctrl(1, 2'd0, 0, 0, 0),
                mk_pdiv(3'd6, 2'd2, 32'hFFFF_FFFF), 32'hFFFF_FFFF);
        run_req("R8 select lowf const", 3'd3, mk_ctrl(1, 2'd0, 0, 0, 0), 0, 32'd123);
        run_req("R8 select none", 3'd0, mk_ctrl(1, 2'd0, 0, 0, 0), 0, 32'd123);
        run_req("R9 select 5 unsupported", 3'd5, mk_ctrl(1, 2'd0, 0, 0, 0), 0, 32'd9);
        run_req("R9 select 7 unsupported", 3'd7, 0, 0, 0);
        run_req("R9 R12 flag clears on periph", 3'd1, mk_ctrl(0, 2'd0, 0, 0, 0),
                mk_pdiv(3'd4, 2'd3, 0), 32'd0);

        // R10: result holds while inputs move and no request is made
        held_f = freq_hz_o; held_u = unsup_o;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            clk_sel_i = 3'(i); ctrl_i = 32'h5A5A_0000 + i; pdiv_i = ~pdiv_i; pll_hz_i = i;
        end
        #1;
        check("R10 freq held", freq_hz_o == held_f, freq_hz_o, held_f);
        check("R10 flag and done held", {unsup_o, done_o} == {held_u, 1'b0},
              {30'd0, unsup_o, done_o}, {30'd0, held_u, 1'b0});

        // R11: second start while busy is dropped
        begin
            exp_t e;
            logic [32:0] m;
            @(negedge clk);
            clk_sel_i = 3'd1; ctrl_i = mk_ctrl(0, 2'd0, 0, 0, 0);
            pdiv_i = mk_pdiv(3'd2, 2'd1, 0); pll_hz_i = 0; start_i = 1'b1;
            m = model(3'd1, ctrl_i, pdiv_i, 0);
            e.f = m[31:0]; e.u = m[32]; e.tag = "R11 first request survives";
            e.due = cyc + longint'(2 * W + 3);
            exp_q.push_back(e);
            @(negedge clk) start_i = 1'b0;
            repeat (4) @(negedge clk);
            check("R11 busy while dividing", busy_o == 1'b1, {31'd0, busy_o}, 1);
            clk_sel_i = 3'd3; ctrl_i = mk_ctrl(1, 2'd2, 1, 1, 0);
            pdiv_i = mk_pdiv(3'd7, 2'd3, 0); start_i = 1'b1;
            @(negedge clk) start_i = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (6) @(negedge clk);
            check("R11 idle after done", busy_o == 1'b0, {31'd0, busy_o}, 0);
        end

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule